// File: doc/BRIEF.md
# Timestamp-Priority Transaction Conflict Resolver

Each node of a cache-coherent multiprocessor runs lock-free critical sections as speculative transactions. This block is the node's referee for those transactions. It holds the node's transaction timestamp, formed by placing a local commit counter above the node's fixed identifier. Every request the node sends while a transaction is open carries this value. When a coherence request from another node hits a block that the local transaction is holding, the block compares the two timestamps. The smaller one is older, and the older transaction wins.

If the local transaction is older, the requester is told to wait and its id is placed in a small waiter queue. If the requester is older, its request is granted and the local transaction is told to restart and drop every block it holds. A restarted transaction keeps its timestamp. The counter moves forward only after a successful commit. At that point the block signals the commit, releases the queued waiters one per cycle, and only then advances the timestamp. Because of this, every node in time holds the oldest timestamp in the system and must then succeed. If the local transaction runs out of buffer space or reaches an operation that cannot be undone, it falls back to taking the real lock. From then on it can no longer be restarted.

Top module: `tsConflictResolver`

## Requirements
- R1: `outTs` equals `{counter, NODE_ID}` with the counter cleared by reset; with the defaults (NODE_ID=2, ID_W=3) the value is counter*8+2.
- R2: In a speculative transaction, a request with `reqConflict`=1 and `reqTs` > `outTs` gets `respValid`=1 and `respCode`=1 (WAIT) one cycle later, with no restart, and its `reqId` is queued.
- R3: In a speculative transaction, a request with `reqConflict`=1 and `reqTs` <= `outTs` gets `respCode`=0 (GRANT) one cycle later, together with a one-cycle `restartTx` pulse (restart and release all held blocks). The transaction stays open.
- R4: `outTs` does not change while `inTx` is high, including across any number of restarts.
- R5: The counter increases by exactly one per successful commit and at no other time.
- R6: `txEnd` in an open transaction produces, in order: one `commitPulse` cycle; then one `wakeValid` cycle per queued waiter, in arrival order, with `wakeId` set; then the counter advance, with `inTx` low from the commit cycle onward.
- R7: `bufFull` or `irrevocable` in a speculative transaction raises `lockReq` from the next cycle until commit. While `lockReq` is high, every conflicting request gets WAIT (or RETRY) whatever its timestamp, and no restart occurs.
- R8: With the waiter queue full (WAITER_DEPTH entries), a request that would wait gets `respCode`=2 (RETRY) and is not queued.
- R9: A request with `reqConflict`=0, or one that arrives with no transaction open, gets GRANT with no restart and no queuing.
- R10: In one cycle, a lost conflict takes precedence over `txEnd`, `bufFull` and `irrevocable`: the transaction restarts, and it neither commits nor falls back in that cycle.
- R11: During and right after reset, `inTx`, `lockReq`, `respValid`, `restartTx`, `commitPulse` and `wakeValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txStart | input | 1 | Open a transaction (taken when idle) |
| txEnd | input | 1 | Transaction reached its end; commit |
| bufFull | input | 1 | Speculative buffer has no free space |
| irrevocable | input | 1 | An operation that cannot be undone is next |
| reqValid | input | 1 | Incoming coherence request present |
| reqConflict | input | 1 | Request hits a block the local transaction holds |
| reqId | input | ID_W | Node id of the requester |
| reqTs | input | CNT_W+ID_W | Timestamp attached to the request |
| outTs | output | CNT_W+ID_W | Local timestamp for outgoing requests |
| inTx | output | 1 | Transaction open (speculative or locked) |
| lockReq | output | 1 | Fallback to explicit lock acquisition |
| respValid | output | 1 | Response to last cycle's request |
| respCode | output | 2 | 0 GRANT, 1 WAIT, 2 RETRY |
| restartTx | output | 1 | Restart transaction and release held blocks |
| commitPulse | output | 1 | Commit the buffered updates now |
| wakeValid | output | 1 | A queued waiter is released |
| wakeId | output | ID_W | Id of the released waiter |

## Verification
Conflicting requests are sent with timestamps both above and below the local one, so a swapped or inverted comparison shows up as a wrong response and a wrong restart. Runs of restarts followed by a commit show whether the timestamp is held during the transaction and advanced only once, after the last waiter is released. Filling the queue past its depth separates WAIT from RETRY and checks that waiters are released in order. Cycles that carry both a lost conflict and `txEnd` or a fallback trigger, plus older requests sent while the lock is held, check the priority between events and the locked mode.

// File: rtl/tsResolverPkg.sv
package tsResolverPkg;

  typedef enum logic [1:0] {
    RESP_GRANT = 2'd0,
    RESP_WAIT  = 2'd1,
    RESP_RETRY = 2'd2
  } respCodeE;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SPEC   = 2'd1,
    ST_LOCKED = 2'd2,
    ST_DRAIN  = 2'd3
  } txStateE;

  typedef struct packed {
    logic pushWaiter;
    logic popWaiter;
    logic advanceTs;
  } dpStrobeS;

endpackage

// File: rtl/waiterFifo.sv
module waiterFifo #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] used;

  assign full     = (used == CNT_W'(DEPTH));
  assign empty    = (used == '0);
  assign headData = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !full) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      used  <= '0;
    end else begin
      if (push && !full) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push && !full, pop && !empty})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/tsDatapath.sv
module tsDatapath
  import tsResolverPkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int ID_W         = 3,
  parameter int NODE_ID      = 0,
  parameter int WAITER_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobeS              strobe,
  input  logic [ID_W-1:0]       pushId,
  input  logic [CNT_W+ID_W-1:0] reqTs,
  output logic [CNT_W+ID_W-1:0] localTs,
  output logic                  reqIsLater,
  output logic                  fifoFull,
  output logic                  fifoEmpty,
  output logic [ID_W-1:0]       wakeId
);
  localparam logic [ID_W-1:0] SELF = ID_W'(NODE_ID);

  logic [CNT_W-1:0] commitCnt;
  logic [ID_W-1:0]  headId;
  logic [ID_W-1:0]  wakeIdQ;

  assign localTs    = {commitCnt, SELF};
  assign reqIsLater = (reqTs > localTs);
  assign wakeId     = wakeIdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitCnt <= '0;
      wakeIdQ   <= '0;
    end else begin
      if (strobe.advanceTs) commitCnt <= commitCnt + 1'b1;
      if (strobe.popWaiter) wakeIdQ <= headId;
    end
  end

  waiterFifo #(.DEPTH(WAITER_DEPTH), .W(ID_W)) uWaiters (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.pushWaiter),
    .pushData (pushId),
    .pop      (strobe.popWaiter),
    .headData (headId),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );
endmodule

// File: rtl/resolverCtrl.sv
module resolverCtrl
  import tsResolverPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txStart,
  input  logic     txEnd,
  input  logic     bufFull,
  input  logic     irrevocable,
  input  logic     reqValid,
  input  logic     reqConflict,
  input  logic     reqIsLater,
  input  logic     fifoFull,
  input  logic     fifoEmpty,
  output dpStrobeS strobe,
  output logic     inTx,
  output logic     lockReq,
  output logic     respValid,
  output logic [1:0] respCode,
  output logic     restartTx,
  output logic     commitPulse,
  output logic     wakeValid
);
  txStateE  state, stateNext;
  respCodeE codeNext;
  logic     holding, conflictHere, mustWait, loseNow, enterDrain;

  assign holding      = (state == ST_SPEC) || (state == ST_LOCKED);
  assign conflictHere = reqValid && reqConflict && holding;
  assign mustWait     = conflictHere && ((state == ST_LOCKED) || reqIsLater);
  assign loseNow      = conflictHere && !mustWait;

  always_comb begin
    strobe.pushWaiter = mustWait && !fifoFull;
    strobe.popWaiter  = (state == ST_DRAIN) && !fifoEmpty;
    strobe.advanceTs  = (state == ST_DRAIN) && fifoEmpty;
  end

  always_comb begin
    if (mustWait) codeNext = fifoFull ? RESP_RETRY : RESP_WAIT;
    else          codeNext = RESP_GRANT;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (txStart) stateNext = ST_SPEC;
      ST_SPEC: begin
        if (loseNow)                     stateNext = ST_SPEC;
        else if (bufFull || irrevocable) stateNext = ST_LOCKED;
        else if (txEnd)                  stateNext = ST_DRAIN;
      end
      ST_LOCKED: if (txEnd) stateNext = ST_DRAIN;
      ST_DRAIN:  if (fifoEmpty) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign enterDrain = (stateNext == ST_DRAIN) && (state != ST_DRAIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      respValid   <= 1'b0;
      respCode    <= RESP_GRANT;
      restartTx   <= 1'b0;
      commitPulse <= 1'b0;
      wakeValid   <= 1'b0;
    end else begin
      state       <= stateNext;
      respValid   <= reqValid;
      respCode    <= codeNext;
      restartTx   <= loseNow;
      commitPulse <= enterDrain;
      wakeValid   <= strobe.popWaiter;
    end
  end

  assign inTx    = holding;
  assign lockReq = (state == ST_LOCKED);
endmodule

// File: rtl/tsConflictResolver.sv
module tsConflictResolver
  import tsResolverPkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int ID_W         = 3,
  parameter int NODE_ID      = 2,
  parameter int WAITER_DEPTH = 4,
  localparam int TS_W        = CNT_W + ID_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            txStart,
  input  logic            txEnd,
  input  logic            bufFull,
  input  logic            irrevocable,
  input  logic            reqValid,
  input  logic            reqConflict,
  input  logic [ID_W-1:0] reqId,
  input  logic [TS_W-1:0] reqTs,
  output logic [TS_W-1:0] outTs,
  output logic            inTx,
  output logic            lockReq,
  output logic            respValid,
  output logic [1:0]      respCode,
  output logic            restartTx,
  output logic            commitPulse,
  output logic            wakeValid,
  output logic [ID_W-1:0] wakeId
);
  dpStrobeS strobe;
  logic     reqIsLater, fifoFull, fifoEmpty;

  resolverCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .txStart     (txStart),
    .txEnd       (txEnd),
    .bufFull     (bufFull),
    .irrevocable (irrevocable),
    .reqValid    (reqValid),
    .reqConflict (reqConflict),
    .reqIsLater  (reqIsLater),
    .fifoFull    (fifoFull),
    .fifoEmpty   (fifoEmpty),
    .strobe      (strobe),
    .inTx        (inTx),
    .lockReq     (lockReq),
    .respValid   (respValid),
    .respCode    (respCode),
    .restartTx   (restartTx),
    .commitPulse (commitPulse),
    .wakeValid   (wakeValid)
  );

  tsDatapath #(
    .CNT_W        (CNT_W),
    .ID_W         (ID_W),
    .NODE_ID      (NODE_ID),
    .WAITER_DEPTH (WAITER_DEPTH)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pushId     (reqId),
    .reqTs      (reqTs),
    .localTs    (outTs),
    .reqIsLater (reqIsLater),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty),
    .wakeId     (wakeId)
  );
endmodule

// File: rtl/resolverChecker.sv
module resolverChecker #(
  parameter int TS_W = 11,
  parameter int ID_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqConflict,
  input logic [TS_W-1:0] reqTs,
  input logic [TS_W-1:0] outTs,
  input logic            inTx,
  input logic            lockReq,
  input logic            respValid,
  input logic [1:0]      respCode,
  input logic            restartTx,
  input logic            commitPulse,
  input logic            wakeValid
);
  localparam logic [TS_W-1:0] TS_STEP = TS_W'(1) << ID_W;

  p_later_waits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqConflict && inTx && !lockReq && (reqTs > outTs))
      |=> (respValid && respCode != 2'd0 && !restartTx));

  p_earlier_restarts_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqConflict && inTx && !lockReq && (reqTs < outTs))
      |=> (restartTx && respCode == 2'd0));

  p_ts_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    inTx |=> $stable(outTs));

  p_ts_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outTs != $past(outTs)) |-> (outTs == $past(outTs) + TS_STEP));

  p_pulses_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({restartTx, commitPulse, wakeValid}));

  p_wake_outside_tx_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeValid |-> !inTx);

  p_lock_in_tx_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockReq |-> inTx);

  p_locked_never_grants_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqConflict && lockReq) |=> (respCode != 2'd0 && !restartTx));
endmodule

bind tsConflictResolver resolverChecker #(.TS_W(TS_W), .ID_W(ID_W)) uChecker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqConflict (reqConflict),
  .reqTs       (reqTs),
  .outTs       (outTs),
  .inTx        (inTx),
  .lockReq     (lockReq),
  .respValid   (respValid),
  .respCode    (respCode),
  .restartTx   (restartTx),
  .commitPulse (commitPulse),
  .wakeValid   (wakeValid)
);

// File: tb/tb_tsConflictResolver.sv
`timescale 1ns/1ps
module tb_tsConflictResolver;
  localparam int CNT_W = 8;
  localparam int ID_W  = 3;
  localparam int NODE  = 2;
  localparam int DEPTH = 4;
  localparam int TS_W  = CNT_W + ID_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txStart = 0, txEnd = 0, bufFull = 0, irrevocable = 0;
  logic reqValid = 0, reqConflict = 0;
  logic [ID_W-1:0] reqId = '0;
  logic [TS_W-1:0] reqTs = '0;
  logic [TS_W-1:0] outTs;
  logic inTx, lockReq, respValid, restartTx, commitPulse, wakeValid;
  logic [1:0] respCode;
  logic [ID_W-1:0] wakeId;

  always #4 clk = ~clk;

  tsConflictResolver #(.CNT_W(CNT_W), .ID_W(ID_W), .NODE_ID(NODE), .WAITER_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txEnd(txEnd), .bufFull(bufFull),
    .irrevocable(irrevocable), .reqValid(reqValid), .reqConflict(reqConflict),
    .reqId(reqId), .reqTs(reqTs), .outTs(outTs), .inTx(inTx), .lockReq(lockReq),
    .respValid(respValid), .respCode(respCode), .restartTx(restartTx),
    .commitPulse(commitPulse), .wakeValid(wakeValid), .wakeId(wakeId)
  );

  // behavioural reference: 0 idle, 1 speculative, 2 locked, 3 releasing waiters
  int mSt = 0;
  int mCnt = 0;
  int mQ[$];
  int eRespValid = 0, eRespCode = 0, eRestart = 0, eCommit = 0, eWake = 0, eWakeId = 0;
  bit started = 0;
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always @(posedge clk) begin
    int myTs;
    bit lost;
    cycles++;
    if (!rstN) begin
      mSt = 0; mCnt = 0; mQ.delete();
      eRespValid = 0; eRespCode = 0; eRestart = 0; eCommit = 0; eWake = 0; eWakeId = 0;
    end else begin
      myTs = mCnt * 8 + NODE;
      lost = 0;
      eRespValid = reqValid; eRespCode = 0; eRestart = 0; eCommit = 0; eWake = 0;
      if (reqValid && reqConflict && (mSt == 1 || mSt == 2)) begin
        if (mSt == 2 || int'(reqTs) > myTs) begin
          if (mQ.size() == DEPTH) eRespCode = 2;
          else begin mQ.push_back(int'(reqId)); eRespCode = 1; end
        end else lost = 1;
      end
      case (mSt)
        0: if (txStart) mSt = 1;
        1: if (lost) eRestart = 1;
           else if (bufFull || irrevocable) mSt = 2;
           else if (txEnd) begin mSt = 3; eCommit = 1; end
        2: if (txEnd) begin mSt = 3; eCommit = 1; end
        default: if (mQ.size() > 0) begin eWake = 1; eWakeId = mQ.pop_front(); end
                 else begin mCnt = (mCnt + 1) % 256; mSt = 0; end
      endcase
    end
    started = 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      vectors++;
      chk("R1 R4 R5 outTs", int'(outTs), mCnt * 8 + NODE);
      chk("R11 inTx", int'(inTx), int'(mSt == 1 || mSt == 2));
      chk("R7 lockReq", int'(lockReq), int'(mSt == 2));
      chk("R9 respValid", int'(respValid), eRespValid);
      if (eRespValid != 0) chk("R2 R3 R8 R9 respCode", int'(respCode), eRespCode);
      chk("R3 R10 restartTx", int'(restartTx), eRestart);
      chk("R6 commitPulse", int'(commitPulse), eCommit);
      chk("R6 wakeValid", int'(wakeValid), eWake);
      if (eWake != 0) chk("R6 wakeId", int'(wakeId), eWakeId);
    end
  end

  task automatic drive(input bit s, input bit e, input bit bf, input bit irr,
                       input bit rv, input bit rc, input int rid, input int rts);
    @(posedge clk); #2;
    txStart = s; txEnd = e; bufFull = bf; irrevocable = irr;
    reqValid = rv; reqConflict = rc; reqId = ID_W'(rid); reqTs = TS_W'(rts);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    wait (cycles > 3000);
    miscompares++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R11: reset state
    idle(3);
    @(posedge clk); #2; rstN = 1'b1;
    idle(2);
    // R9: request with no transaction open
    drive(0, 0, 0, 0, 1, 1, 1, 1);
    drive(1, 0, 0, 0, 0, 0, 0, 0);          // open, ts = 2
    drive(0, 0, 0, 0, 1, 0, 1, 1);          // R9 non-conflicting
    drive(0, 0, 0, 0, 1, 1, 5, 5);          // R2 later -> WAIT
    drive(0, 0, 0, 0, 1, 1, 1, 1);          // R3 earlier -> restart
    drive(0, 0, 0, 0, 1, 1, 3, 19);         // R4 still same ts, WAIT
    drive(0, 1, 0, 0, 0, 0, 0, 0);          // R6 commit
    idle(5);
    // R8: fill queue, ts now 10
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 1, 1, 4 + i, 20 + i);
    drive(0, 0, 0, 0, 1, 1, 1, 30);         // RETRY
    drive(0, 0, 0, 0, 1, 1, 0, 8);          // restart
    drive(0, 0, 0, 0, 1, 1, 1, 9);          // restart again, R4
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    idle(8);
    // R7: irrevocable fallback, ts now 18
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 1, 1, 1);          // older, still WAIT
    drive(0, 0, 0, 0, 1, 0, 3, 3);          // non-conflicting GRANT
    idle(2);
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    idle(4);
    // R10: priorities, ts now 26
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 1, 1, 0, 0);          // lost conflict beats txEnd
    drive(0, 0, 1, 0, 1, 1, 1, 9);          // lost conflict beats bufFull
    drive(0, 0, 0, 1, 1, 1, 6, 0);          // lost conflict beats irrevocable
    drive(0, 0, 1, 0, 0, 0, 0, 0);          // R7 bufFull fallback
    drive(0, 0, 0, 0, 1, 1, 7, 50);
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    idle(4);
    // empty commit: counter still advances once
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule